// File: doc/BRIEF.md
# Dual-Phase Serial Frame Transmitter

This block turns parallel data words into a framed serial bit stream for audio and PCM links. A frame is made of one or two phases; each phase carries its own count of elements, and every element in a phase has the same programmable bit length. All activity advances on a single-cycle bit-clock enable, so the block runs in the system clock domain and a separate generator supplies the bit rate and the frame sync.

When a frame sync is seen on an enabled cycle, the first bit leaves a programmable 0 to 3 bit periods later. Elements go out back to back, each taken from the transmit buffer through a valid/ready handshake at the moment the element begins. Phase 2 either follows phase 1 with no gap or waits for the next frame sync. A sync that arrives while a frame is still in progress raises an error strobe and, by configuration, either restarts the frame or is ignored. When no word is ready for an element, the element is sent as zeros and an underrun strobe fires. The configuration inputs are expected to stay stable while a frame is in progress.

Top module: `serial_frame_tx`

## Requirements
- R1: The 3-bit element length code selects the bits per element: code 0..7 gives 8, 10, 12, 14, 16, 20, 24, 32 bits.
- R2: A phase count code of N sends N+1 elements in that phase (0 gives one element, 63 gives 64).
- R3: With the phase-2 enable low, a frame is phase 1 only, and busy falls in the bit period right after the last phase-1 bit.
- R4: With phase 2 enabled and the wait-for-sync bit low, the first phase-2 bit follows the last phase-1 bit with no gap; with it high, the line stays low and busy stays high until a frame sync, after which phase 2 starts with the same data delay as phase 1.
- R5: If a frame sync is seen on enabled cycle S and the delay code is D (0..3), the first data bit is on the line during the bit period that starts at enabled cycle S+D.
- R6: With the bit-order input at 0 an element goes most significant bit first, at 1 least significant bit first; an element of L bits uses bits L-1..0 of its word and ignores the bits above.
- R7: A frame sync seen while a frame is in progress (anything except idle, the phase-2 wait, or the enabled cycle that ends the frame) pulses sync_err; with the ignore bit low the current element stops at once, the line and busy go low, and a new frame starts from that sync with the configured delay.
- R8: With the ignore bit high, an unexpected frame sync still pulses sync_err but leaves the bit stream, busy and the data taken unchanged.
- R9: If no word is valid when an element begins, that element is sent as all zeros, underrun pulses for one clock, and the frame keeps its full length.
- R10: busy is high from the first data bit of a frame through the last bit of its final phase, and the line is low whenever busy is low.
- R11: tx_ready is high only in an enabled cycle in which an element begins, so one word is taken per element, and svc_req pulses for one clock after each element start.
- R12: Out of reset sdo, busy, tx_ready, underrun, sync_err and svc_req are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | Bit-clock enable, one clock per bit period |
| fsync | input | 1 | Frame sync, sampled on enabled cycles |
| cfg_p1_len | input | 3 | Phase-1 element length code |
| cfg_p1_cnt | input | CNT_W | Phase-1 element count minus one |
| cfg_p2_on | input | 1 | Enable a second phase |
| cfg_p2_len | input | 3 | Phase-2 element length code |
| cfg_p2_cnt | input | CNT_W | Phase-2 element count minus one |
| cfg_p2_on_sync | input | 1 | 1: phase 2 waits for a frame sync; 0: starts at once |
| cfg_delay | input | DLY_W | Bit periods from sync to first bit |
| cfg_lsb_first | input | 1 | 0: MSB first; 1: LSB first |
| cfg_sync_ignore | input | 1 | 1: ignore unexpected syncs; 0: restart the frame |
| tx_data | input | WORD_W | Data word from the transmit buffer |
| tx_valid | input | 1 | tx_data holds a word |
| tx_ready | output | 1 | Word taken in this cycle |
| sdo | output | 1 | Serial data line |
| busy | output | 1 | Frame in progress |
| underrun | output | 1 | One-clock strobe: element sent without data |
| sync_err | output | 1 | One-clock strobe: unexpected frame sync |
| svc_req | output | 1 | One-clock strobe: element started, buffer may refill |

## Verification
The bench builds the block with its defaults, WORD_W of 32, CNT_W of 6 and DLY_W of 2, so every length code up to the full 32-bit element and every delay from 0 to 3 can be reached. Counts are kept to at most twelve elements per phase so that dual-phase frames, the phase-2 wait gap, aborts and underruns fit in short runs. Directed frames cover the two-phase twelve-element case, the single 32-bit element with one bit of delay, the abort and ignore reactions to a mid-frame sync, and missing data, while seeded random configurations mix length, order, delay and phase-2 start mode.

// File: rtl/serial_frame_tx_pkg.sv
package serial_frame_tx_pkg;

  localparam int LEN_CODE_W = 3;
  localparam int LEN_BITS_W = 6;

  typedef enum logic [2:0] {
    SQ_IDLE   = 3'd0,
    SQ_DELAY  = 3'd1,
    SQ_PHASE1 = 3'd2,
    SQ_GAP    = 3'd3,
    SQ_PHASE2 = 3'd4
  } seq_state_e;

  // Element length code to number of bits per element.
  function automatic logic [LEN_BITS_W-1:0] len_code_to_bits(input logic [LEN_CODE_W-1:0] code);
    logic [LEN_BITS_W-1:0] bits;
    case (code)
      3'd0:    bits = 6'd8;
      3'd1:    bits = 6'd10;
      3'd2:    bits = 6'd12;
      3'd3:    bits = 6'd14;
      3'd4:    bits = 6'd16;
      3'd5:    bits = 6'd20;
      3'd6:    bits = 6'd24;
      default: bits = 6'd32;
    endcase
    return bits;
  endfunction

endpackage

// File: rtl/serial_frame_tx_seq.sv
module serial_frame_tx_seq
  import serial_frame_tx_pkg::*;
#(
  parameter int CNT_W = 6,
  parameter int DLY_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             fsync,
  input  logic [CNT_W-1:0] p1_cnt,
  input  logic             p2_on,
  input  logic [CNT_W-1:0] p2_cnt,
  input  logic             p2_on_sync,
  input  logic [DLY_W-1:0] delay,
  input  logic             sync_ignore,
  input  logic             sh_active,
  input  logic             sh_last,
  output logic             load,
  output logic             load_ph2,
  output logic             kill,
  output logic             busy,
  output logic             sync_err
);

  seq_state_e       st_q, st_d;
  logic [DLY_W-1:0] dcnt_q, dcnt_d;
  logic             dph2_q, dph2_d;
  logic [CNT_W-1:0] ecnt_q, ecnt_d;
  logic             sync_expected;
  logic             start_p2;

  always_comb begin
    st_d          = st_q;
    dcnt_d        = dcnt_q;
    dph2_d        = dph2_q;
    ecnt_d        = ecnt_q;
    load          = 1'b0;
    load_ph2      = 1'b0;
    kill          = 1'b0;
    sync_err      = 1'b0;
    sync_expected = 1'b0;
    start_p2      = 1'b0;
    if (tick) begin
      // Normal advance of the frame for this bit period.
      case (st_q)
        SQ_DELAY: begin
          if (dcnt_q == '0) begin
            load     = 1'b1;
            load_ph2 = dph2_q;
            ecnt_d   = dph2_q ? p2_cnt : p1_cnt;
            st_d     = dph2_q ? SQ_PHASE2 : SQ_PHASE1;
          end else begin
            dcnt_d = dcnt_q - 1'b1;
          end
        end
        SQ_PHASE1, SQ_PHASE2: begin
          if (sh_last) begin
            if (ecnt_q != '0) begin
              load     = 1'b1;
              load_ph2 = (st_q == SQ_PHASE2);
              ecnt_d   = ecnt_q - 1'b1;
            end else if ((st_q == SQ_PHASE1) && p2_on) begin
              if (p2_on_sync) begin
                st_d = SQ_GAP;
              end else begin
                load     = 1'b1;
                load_ph2 = 1'b1;
                ecnt_d   = p2_cnt;
                st_d     = SQ_PHASE2;
              end
            end else begin
              st_d = SQ_IDLE;
            end
          end
        end
        default: ;
      endcase
      // Frame sync handling, judged against the state this tick reaches.
      if (fsync) begin
        sync_expected = (st_d == SQ_IDLE) || (st_d == SQ_GAP);
        sync_err      = !sync_expected;
        if (sync_expected || !sync_ignore) begin
          start_p2 = sync_expected && (st_d == SQ_GAP);
          kill     = !sync_expected;
          dph2_d   = start_p2;
          if (delay == '0) begin
            load     = 1'b1;
            load_ph2 = start_p2;
            ecnt_d   = start_p2 ? p2_cnt : p1_cnt;
            st_d     = start_p2 ? SQ_PHASE2 : SQ_PHASE1;
          end else begin
            load     = 1'b0;
            load_ph2 = 1'b0;
            dcnt_d   = delay - 1'b1;
            st_d     = SQ_DELAY;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      dcnt_q <= '0;
      dph2_q <= 1'b0;
      ecnt_q <= '0;
    end else begin
      st_q   <= st_d;
      dcnt_q <= dcnt_d;
      dph2_q <= dph2_d;
      ecnt_q <= ecnt_d;
    end
  end

  assign busy = (st_q == SQ_PHASE1) || (st_q == SQ_PHASE2) || (st_q == SQ_GAP) ||
                ((st_q == SQ_DELAY) && dph2_q);

  // R4: no element is being shifted while waiting for phase 2 or a delay.
  a_r4_gap_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == SQ_GAP) || (st_q == SQ_DELAY)) |-> !sh_active);

  // R2: the element countdown only moves on enabled cycles.
  a_r2_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ecnt_q));

endmodule

// File: rtl/serial_frame_tx_shift.sv
module serial_frame_tx_shift
  import serial_frame_tx_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(WORD_W)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  load,
  input  logic                  kill,
  input  logic [WORD_W-1:0]     load_word,
  input  logic                  load_valid,
  input  logic [LEN_CODE_W-1:0] len_code,
  input  logic                  lsb_first,
  output logic                  sdo,
  output logic                  active,
  output logic                  last
);

  logic [WORD_W-1:0]     word_q, word_d;
  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [IDX_W-1:0]      rem_q, rem_d;
  logic                  lsb_q, lsb_d;
  logic                  act_q, act_d;
  logic [LEN_BITS_W-1:0] len_bits;
  logic [IDX_W-1:0]      len_m1;

  assign len_bits = len_code_to_bits(len_code);
  assign len_m1   = IDX_W'(len_bits - 6'd1);

  always_comb begin
    word_d = word_q;
    idx_d  = idx_q;
    rem_d  = rem_q;
    lsb_d  = lsb_q;
    act_d  = act_q;
    if (tick) begin
      if (load) begin
        word_d = load_valid ? load_word : '0;
        lsb_d  = lsb_first;
        rem_d  = len_m1;
        idx_d  = lsb_first ? '0 : len_m1;
        act_d  = 1'b1;
      end else if (kill || (act_q && (rem_q == '0))) begin
        act_d = 1'b0;
      end else if (act_q) begin
        rem_d = rem_q - 1'b1;
        idx_d = lsb_q ? (idx_q + 1'b1) : (idx_q - 1'b1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
      rem_q  <= '0;
      lsb_q  <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      idx_q  <= idx_d;
      rem_q  <= rem_d;
      lsb_q  <= lsb_d;
      act_q  <= act_d;
    end
  end

  assign sdo    = act_q & word_q[idx_q];
  assign active = act_q;
  assign last   = act_q && (rem_q == '0);

  // R6: the bit pointer holds between enabled cycles.
  a_r6_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(idx_q) && $stable(act_q)));

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import serial_frame_tx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6,
  parameter int DLY_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bit_en,
  input  logic                  fsync,
  input  logic [LEN_CODE_W-1:0] cfg_p1_len,
  input  logic [CNT_W-1:0]      cfg_p1_cnt,
  input  logic                  cfg_p2_on,
  input  logic [LEN_CODE_W-1:0] cfg_p2_len,
  input  logic [CNT_W-1:0]      cfg_p2_cnt,
  input  logic                  cfg_p2_on_sync,
  input  logic [DLY_W-1:0]      cfg_delay,
  input  logic                  cfg_lsb_first,
  input  logic                  cfg_sync_ignore,
  input  logic [WORD_W-1:0]     tx_data,
  input  logic                  tx_valid,
  output logic                  tx_ready,
  output logic                  sdo,
  output logic                  busy,
  output logic                  underrun,
  output logic                  sync_err,
  output logic                  svc_req
);

  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  logic       ld, ld_ph2, kill, seq_err;
  logic       sh_active, sh_last;
  logic       und_q, und_d, err_q, err_d, svc_q, svc_d;
  logic [LEN_CODE_W-1:0] len_sel;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  serial_frame_tx_seq #(.CNT_W(CNT_W), .DLY_W(DLY_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .tick        (bit_en),
    .fsync       (fsync),
    .p1_cnt      (cfg_p1_cnt),
    .p2_on       (cfg_p2_on),
    .p2_cnt      (cfg_p2_cnt),
    .p2_on_sync  (cfg_p2_on_sync),
    .delay       (cfg_delay),
    .sync_ignore (cfg_sync_ignore),
    .sh_active   (sh_active),
    .sh_last     (sh_last),
    .load        (ld),
    .load_ph2    (ld_ph2),
    .kill        (kill),
    .busy        (busy),
    .sync_err    (seq_err)
  );

  assign len_sel = ld_ph2 ? cfg_p2_len : cfg_p1_len;

  serial_frame_tx_shift #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .tick       (bit_en),
    .load       (ld),
    .kill       (kill),
    .load_word  (tx_data),
    .load_valid (tx_valid),
    .len_code   (len_sel),
    .lsb_first  (cfg_lsb_first),
    .sdo        (sdo),
    .active     (sh_active),
    .last       (sh_last)
  );

  assign tx_ready = ld;

  always_comb begin
    und_d = ld & !tx_valid;
    svc_d = ld;
    err_d = seq_err;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      und_q <= 1'b0;
      err_q <= 1'b0;
      svc_q <= 1'b0;
    end else begin
      und_q <= und_d;
      err_q <= err_d;
      svc_q <= svc_d;
    end
  end

  assign underrun = und_q;
  assign sync_err = err_q;
  assign svc_req  = svc_q;

  // R10: the line is quiet outside a frame.
  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy |-> !sdo);

  // R10: every shifted bit lies inside the busy window.
  a_r10_bits_inside_busy: assert property (@(posedge clk) disable iff (!rst_n_s)
    sh_active |-> busy);

  // R9: an element started without data drives zeros.
  a_r9_underrun_drives_zero: assert property (@(posedge clk) disable iff (!rst_n_s)
    underrun |-> !sdo);

  // R7: a sync error only follows a sync on an enabled cycle.
  a_r7_err_needs_sync: assert property (@(posedge clk) disable iff (!rst_n_s)
    sync_err |-> $past(fsync && bit_en));

  // R11: a service strobe only follows an enabled cycle.
  a_r11_svc_after_tick: assert property (@(posedge clk) disable iff (!rst_n_s)
    svc_req |-> $past(bit_en));

endmodule

// File: tb/serial_frame_tx_test.sv
module serial_frame_tx_test;

  localparam int WORD_W = 32;
  localparam int CNT_W  = 6;
  localparam int DLY_W  = 2;
  localparam int NT     = 400;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, bit_en, fsync;
  logic [2:0]        cfg_p1_len, cfg_p2_len;
  logic [CNT_W-1:0]  cfg_p1_cnt, cfg_p2_cnt;
  logic              cfg_p2_on, cfg_p2_on_sync, cfg_lsb_first, cfg_sync_ignore;
  logic [DLY_W-1:0]  cfg_delay;
  logic [WORD_W-1:0] tx_data;
  logic              tx_valid, tx_ready, sdo, busy, underrun, sync_err, svc_req;

  serial_frame_tx #(.WORD_W(WORD_W), .CNT_W(CNT_W), .DLY_W(DLY_W)) uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fsync(fsync),
    .cfg_p1_len(cfg_p1_len), .cfg_p1_cnt(cfg_p1_cnt), .cfg_p2_on(cfg_p2_on),
    .cfg_p2_len(cfg_p2_len), .cfg_p2_cnt(cfg_p2_cnt), .cfg_p2_on_sync(cfg_p2_on_sync),
    .cfg_delay(cfg_delay), .cfg_lsb_first(cfg_lsb_first), .cfg_sync_ignore(cfg_sync_ignore),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .sdo(sdo),
    .busy(busy), .underrun(underrun), .sync_err(sync_err), .svc_req(svc_req)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  bit exp_sdo [NT];
  bit exp_busy[NT];
  bit got_sdo [NT];
  bit got_busy[NT];
  int n_und, n_err, n_svc, n_take;
  logic [31:0] dq[$];
  logic [31:0] mw[$];

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int len_of(int code);
    case (code)
      0: return 8;   1: return 10;  2: return 12;  3: return 14;
      4: return 16;  5: return 20;  6: return 24;  default: return 32;
    endcase
  endfunction

  task automatic clear_all();
    for (int t = 0; t < NT; t++) begin
      exp_sdo[t] = 0; exp_busy[t] = 0; got_sdo[t] = 0; got_busy[t] = 0;
    end
    n_und = 0; n_err = 0; n_svc = 0; n_take = 0;
    dq.delete(); mw.delete();
  endtask

  task automatic add_word(logic [31:0] w);
    dq.push_back(w);
    mw.push_back(w);
  endtask

  task automatic model_phase(inout int t, input int lc, input int cnt, input bit lsb, inout int wi);
    for (int k = 0; k <= cnt; k++) begin
      logic [31:0] w;
      int L;
      w = (wi < mw.size()) ? mw[wi] : 32'd0;
      wi++;
      L = len_of(lc);
      for (int i = 0; i < L; i++)
        if (t + i < NT) exp_sdo[t + i] = lsb ? w[i] : w[L - 1 - i];
      t += L;
    end
  endtask

  task automatic mark_busy(int a, int b);
    for (int t = a; t < b; t++) if (t < NT) exp_busy[t] = 1;
  endtask

  task automatic do_tick(bit fs, int t);
    bit took;
    fsync    = fs;
    bit_en   = 1'b1;
    tx_valid = (dq.size() > 0);
    tx_data  = (dq.size() > 0) ? dq[0] : '0;
    #1;
    took = tx_ready && tx_valid;
    @(posedge clk);
    #1;
    if (took) begin
      void'(dq.pop_front());
      n_take++;
    end
    bit_en = 1'b0;
    fsync  = 1'b0;
    @(negedge clk);
    got_sdo[t]  = sdo;
    got_busy[t] = busy;
    n_und += int'(underrun);
    n_err += int'(sync_err);
    n_svc += int'(svc_req);
    repeat (2) @(negedge clk);
  endtask

  task automatic run(int nt, int s1, int s2);
    for (int t = 0; t < nt; t++) do_tick((t == s1) || (t == s2), t);
  endtask

  task automatic cmp_stream(string tag, int nt);
    int bs, bb;
    bs = -1; bb = -1;
    for (int t = 0; t < nt; t++) begin
      if (got_sdo[t] != exp_sdo[t] && bs < 0) bs = t;
      if (got_busy[t] != exp_busy[t] && bb < 0) bb = t;
    end
    if (bs < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, $sformatf("%s sdo at tick %0d", tag, bs), got_sdo[bs], exp_sdo[bs]);
    if (bb < 0) chk(1'b1, tag, 0, 0);
    else chk(1'b0, $sformatf("R10 %s busy at tick %0d", tag, bb), got_busy[bb], exp_busy[bb]);
  endtask

  task automatic set_cfg(int p1l, int p1c, bit p2on, int p2l, int p2c, bit wait2,
                         int d, bit lsb, bit ign);
    cfg_p1_len = 3'(p1l); cfg_p1_cnt = CNT_W'(p1c); cfg_p2_on = p2on;
    cfg_p2_len = 3'(p2l); cfg_p2_cnt = CNT_W'(p2c); cfg_p2_on_sync = wait2;
    cfg_delay = DLY_W'(d); cfg_lsb_first = lsb; cfg_sync_ignore = ign;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R10 run did not complete actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int t, st, wi, s2, nt, total;
    void'($urandom(32'd20240607));
    rst_n = 1'b0; bit_en = 1'b0; fsync = 1'b0; tx_valid = 1'b0; tx_data = '0;
    set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0);
    repeat (5) @(negedge clk);
    // R12: outputs quiet in and right after reset
    chk(sdo == 1'b0 && busy == 1'b0, "R12 sdo/busy in reset", {sdo, busy}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdo == 1'b0, "R12 sdo after reset", sdo, 0);
    chk(busy == 1'b0, "R12 busy after reset", busy, 0);
    chk({underrun, sync_err, svc_req} == 3'b000, "R12 strobes after reset",
        {underrun, sync_err, svc_req}, 0);
    bit_en = 1'b1; #1;
    chk(tx_ready == 1'b0, "R12 R11 tx_ready idle without sync", tx_ready, 0);
    bit_en = 1'b0;
    @(negedge clk);

    // One 32-bit element, delay 1, MSB first, phase 2 off (R1 R3 R5)
    clear_all();
    set_cfg(7, 0, 0, 0, 0, 0, 1, 0, 0);
    add_word(32'hA5C3_1E0F);
    wi = 0; t = 0 + 1; st = t;
    model_phase(t, 7, 0, 0, wi); mark_busy(st, t);
    run(40, 0, -1);
    cmp_stream("R1 R3 R5 single 32-bit", 40);
    chk(n_take == 1 && n_svc == 1, "R11 one word per element", n_take, 1);

    // Two phases back to back: 1x16 then 12x20, delay 0 (R2 R4)
    clear_all();
    set_cfg(4, 0, 1, 5, 11, 0, 0, 0, 0);
    for (int k = 0; k < 13; k++) add_word($urandom);
    wi = 0; t = 0; st = t;
    model_phase(t, 4, 0, 0, wi); model_phase(t, 5, 11, 0, wi); mark_busy(st, t);
    nt = t + 4;
    run(nt, 0, -1);
    cmp_stream("R2 R4 dual immediate", nt);
    chk(n_svc == 13, "R2 R11 element starts in dual frame", n_svc, 13);

    // Phase 2 waits for sync, delay 1 (R4 R5)
    clear_all();
    set_cfg(4, 0, 1, 5, 11, 1, 1, 0, 0);
    for (int k = 0; k < 13; k++) add_word($urandom);
    wi = 0; t = 1; st = t;
    model_phase(t, 4, 0, 0, wi);
    s2 = t + 3; t = s2 + 1;
    model_phase(t, 5, 11, 0, wi); mark_busy(st, t);
    nt = t + 4;
    run(nt, 0, s2);
    cmp_stream("R4 dual wait-for-sync", nt);
    chk(n_err == 0, "R4 phase-2 sync is expected", n_err, 0);

    // LSB first, 8-bit elements, delay 3, junk in upper bits (R6 R5)
    clear_all();
    set_cfg(0, 3, 0, 0, 0, 0, 3, 1, 0);
    add_word(32'hFFFF_FF5A); add_word(32'h1234_56C3); add_word(32'hDEAD_BE81); add_word(32'h0F0F_0F7E);
    wi = 0; t = 2 + 3; st = t;
    model_phase(t, 0, 3, 1, wi); mark_busy(st, t);
    run(t + 4, 2, -1);
    cmp_stream("R6 R5 lsb-first low bits", t + 4);

    // Underrun: four elements, two words (R9)
    clear_all();
    set_cfg(0, 3, 0, 0, 0, 0, 0, 0, 0);
    add_word(32'h0000_00B7); add_word(32'h0000_00E9);
    wi = 0; t = 0; st = t;
    model_phase(t, 0, 3, 0, wi); mark_busy(st, t);
    run(t + 4, 0, -1);
    cmp_stream("R9 underrun zeros", t + 4);
    chk(n_und == 2, "R9 underrun strobes", n_und, 2);
    chk(n_svc == 4, "R9 R11 counters keep advancing", n_svc, 4);

    // Abort on mid-frame sync, delay 2 (R7)
    clear_all();
    set_cfg(0, 3, 0, 0, 0, 0, 2, 0, 0);
    for (int k = 0; k < 8; k++) add_word($urandom);
    wi = 0; t = 2;
    model_phase(t, 0, 1, 0, wi);
    wi = 2; t = 13;
    model_phase(t, 0, 3, 0, wi);
    exp_sdo[11] = 0; exp_sdo[12] = 0;
    mark_busy(2, 11); mark_busy(13, t);
    run(t + 4, 0, 11);
    cmp_stream("R7 abort and restart", t + 4);
    chk(n_err == 1, "R7 sync error strobe", n_err, 1);
    chk(n_take == 6, "R7 words taken", n_take, 6);

    // Ignore mid-frame sync (R8)
    clear_all();
    set_cfg(0, 3, 0, 0, 0, 0, 2, 0, 1);
    for (int k = 0; k < 8; k++) add_word($urandom);
    wi = 0; t = 2; st = t;
    model_phase(t, 0, 3, 0, wi); mark_busy(st, t);
    run(t + 4, 0, 11);
    cmp_stream("R8 ignored sync", t + 4);
    chk(n_err == 1, "R8 sync error strobe", n_err, 1);
    chk(n_take == 4, "R8 words taken unchanged", n_take, 4);

    // Seeded random configurations (R1 R2 R4 R5 R6 R10 R11)
    for (int r = 0; r < 10; r++) begin
      int p1l, p1c, p2l, p2c, d, s1;
      bit p2on, w2, lsb;
      clear_all();
      p1l = $urandom_range(0, 7); p1c = $urandom_range(0, 3);
      p2l = $urandom_range(0, 7); p2c = $urandom_range(0, 3);
      p2on = $urandom_range(0, 1); w2 = $urandom_range(0, 1);
      lsb = $urandom_range(0, 1); d = $urandom_range(0, 3); s1 = $urandom_range(0, 3);
      set_cfg(p1l, p1c, p2on, p2l, p2c, w2, d, lsb, 0);
      total = (p1c + 1) + (p2on ? (p2c + 1) : 0);
      for (int k = 0; k < total; k++) add_word($urandom);
      wi = 0; t = s1 + d; st = t; s2 = -1;
      model_phase(t, p1l, p1c, lsb, wi);
      if (p2on) begin
        if (w2) begin
          s2 = t + $urandom_range(0, 3);
          t = s2 + d;
        end
        model_phase(t, p2l, p2c, lsb, wi);
      end
      mark_busy(st, t);
      nt = t + 4;
      run(nt, s1, s2);
      cmp_stream($sformatf("R1 R2 R6 random cfg %0d", r), nt);
      chk(n_svc == total && n_take == total, $sformatf("R11 random element starts %0d", r),
          n_svc, total);
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule